// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Resolver with Two-Class Signalling

This block looks at every interrupt source in a grouped interrupt controller and works out, for each CPU, the most urgent source that may be delivered to it. A source takes part for a CPU when it is pending, enabled, and its target mask includes that CPU. Priorities are 8-bit values, and a smaller value is more urgent. When several sources share the same priority, the one with the lowest ID wins.

Each CPU applies two thresholds to its winner, one after the other. The first is the priority mask. A winner whose priority is strictly below the mask becomes that CPU's current pending ID. The second is the running priority. Only a winner whose priority is also strictly below the running priority can raise a signal. The winner's group bit (0 or 1) then selects one enable bit from the distributor control and one from the CPU control. Both selected bits must be set. A group 0 winner raises the fast interrupt line when the CPU has fast signalling enabled. In every other case the winner raises the normal interrupt line.

The outputs are registered and recomputed on every clock. Each CPU's signalling is held in a small state register with three states: SIG_IDLE (no line raised), SIG_IRQ (normal line raised) and SIG_FIQ (fast line raised). The transitions are re-evaluated on every edge: *drop* goes to SIG_IDLE, *raise_irq* goes to SIG_IRQ, and *raise_fiq* goes to SIG_FIQ. Any state can move to any state in one cycle.

Top module: `prio_resolver`

## Requirements
- R1: While reset is held, every CPU has both interrupt lines low and a current pending ID of 1023.
- R2: A source is a candidate for CPU c only when its pending bit is 1, its enable bit is 1 and bit `id*N_CPU + c` of the target vector is 1.
- R3: The candidate with the numerically smallest priority wins. When priorities are equal, the smallest ID wins. IDs 0 and N_IRQ-1 are both reachable.
- R4: The current pending ID is the winner's ID when the winner's priority is strictly below the CPU's mask. Otherwise it is 1023, and this includes the case where the priority equals the mask.
- R5: A line is raised only when the winner's priority is strictly below the CPU's running priority. A winner that passes the mask but not the running priority keeps its ID as pending, and both lines stay low.
- R6: When both distributor group-enable bits are 0, or both of the CPU's group-enable bits are 0, both lines of that CPU are low.
- R7: With group bit g of the winner, bit g of the distributor enable and bit g of the CPU's enable (the 2-bit field `c*2 +: 2`) must both be 1 for any line to be raised. A lower-ranked source of an enabled group does not take the winner's place.
- R8: A group 0 winner raises the fast line when the CPU's fast-enable bit is 1 and the normal line when it is 0. A group 1 winner always raises the normal line.
- R9: A CPU never has both its lines high in the same cycle.
- R10: Outputs change only at a clock edge and reflect the inputs present at that edge. A change made between edges is invisible until the next edge.
- R11: Each CPU's result depends only on its own target bits, control bits, mask and running priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | N_IRQ | Pending bit per source |
| en_i | input | N_IRQ | Enable bit per source |
| grp_i | input | N_IRQ | Group bit per source (0 or 1) |
| prio_i | input | N_IRQ*PRIO_W | Priority per source, source i at `i*PRIO_W +: PRIO_W` |
| tgt_i | input | N_IRQ*N_CPU | Target bits, source i / CPU c at bit `i*N_CPU + c` |
| dist_grp_en_i | input | 2 | Distributor enable, bit 0 group 0, bit 1 group 1 |
| cpu_grp_en_i | input | 2*N_CPU | CPU group enables, CPU c at `c*2 +: 2` |
| cpu_fiq_en_i | input | N_CPU | Fast-line enable per CPU |
| pmask_i | input | N_CPU*PRIO_W | Priority mask per CPU |
| rprio_i | input | N_CPU*PRIO_W | Running priority per CPU |
| irq_o | output | N_CPU | Normal interrupt line per CPU |
| fiq_o | output | N_CPU | Fast interrupt line per CPU |
| cur_id_o | output | N_CPU*10 | Current pending ID per CPU, 1023 when none |

## Verification
The hardest case to reach is a winner that blocks delivery because its own group is disabled while a less urgent source of an enabled group is also pending. A naive design would fall through to that second source. The stimulus sets up exactly this pair, then disables the winner's group first at the distributor and then at the CPU interface, and expects silence both times. The second difficult case is a priority that equals the mask or the running priority exactly. It is reached by moving each threshold to the winner's priority and then to one above it.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
    localparam int          ID_W        = 10;
    localparam logic [9:0]  SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        SIG_IDLE = 2'd0,
        SIG_IRQ  = 2'd1,
        SIG_FIQ  = 2'd2
    } sig_state_e;
endpackage

// File: rtl/prio_pick.sv
// Finds the most urgent eligible source for one CPU.
module prio_pick
    import prio_res_pkg::*;
#(
    parameter int N_IRQ   = 64,
    parameter int N_CPU   = 2,
    parameter int PRIO_W  = 8,
    parameter int CPU_IDX = 0
) (
    input  logic [N_IRQ-1:0]        pend_i,
    input  logic [N_IRQ-1:0]        en_i,
    input  logic [N_IRQ-1:0]        grp_i,
    input  logic [N_IRQ*PRIO_W-1:0] prio_i,
    input  logic [N_IRQ*N_CPU-1:0]  tgt_i,
    output logic [ID_W-1:0]         best_id_o,
    output logic [PRIO_W:0]         best_prio_o,
    output logic                    best_grp_o
);
    localparam logic [PRIO_W:0] SENTINEL = {1'b1, {PRIO_W{1'b0}}};

    always_comb begin
        best_id_o   = SPURIOUS_ID;
        best_prio_o = SENTINEL;
        best_grp_o  = 1'b0;
        for (int i = 0; i < N_IRQ; i++) begin
            // strict compare keeps the lower ID on a tie
            if (pend_i[i] && en_i[i] && tgt_i[i*N_CPU + CPU_IDX] &&
                ({1'b0, prio_i[i*PRIO_W +: PRIO_W]} < best_prio_o)) begin
                best_id_o   = ID_W'(i);
                best_prio_o = {1'b0, prio_i[i*PRIO_W +: PRIO_W]};
                best_grp_o  = grp_i[i];
            end
        end
    end
endmodule

// File: rtl/prio_route.sv
// Mask stage, preemption stage and line selection for one CPU.
module prio_route
    import prio_res_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   best_id_i,
    input  logic [PRIO_W:0]   best_prio_i,
    input  logic              best_grp_i,
    input  logic [1:0]        dist_en_i,
    input  logic [1:0]        cpu_en_i,
    input  logic              fiq_en_i,
    input  logic [PRIO_W-1:0] pmask_i,
    input  logic [PRIO_W-1:0] rprio_i,
    output logic              irq_o,
    output logic              fiq_o,
    output logic [ID_W-1:0]   cur_id_o
);
    sig_state_e state_q, state_d;
    logic       any_on, pass_mask, pass_run, grp_ok;

    assign any_on    = (|dist_en_i) && (|cpu_en_i);
    assign pass_mask = best_prio_i < {1'b0, pmask_i};
    assign pass_run  = best_prio_i < {1'b0, rprio_i};
    assign grp_ok    = dist_en_i[best_grp_i] && cpu_en_i[best_grp_i];

    // transition choice: drop / raise_fiq / raise_irq
    always_comb begin
        if (!any_on || !pass_mask || !pass_run || !grp_ok)
            state_d = SIG_IDLE;
        else if (!best_grp_i && fiq_en_i)
            state_d = SIG_FIQ;
        else
            state_d = SIG_IRQ;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SIG_IDLE;
            cur_id_o <= SPURIOUS_ID;
        end else begin
            state_q  <= state_d;
            cur_id_o <= pass_mask ? best_id_i : SPURIOUS_ID;
        end
    end

    always_comb begin
        irq_o = 1'b0;
        fiq_o = 1'b0;
        unique case (state_q)
            SIG_IDLE: ;
            SIG_IRQ:  irq_o = 1'b1;
            SIG_FIQ:  fiq_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prio_res_pkg::*;
#(
    parameter int N_IRQ  = 64,
    parameter int N_CPU  = 2,
    parameter int PRIO_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IRQ-1:0]        pend_i,
    input  logic [N_IRQ-1:0]        en_i,
    input  logic [N_IRQ-1:0]        grp_i,
    input  logic [N_IRQ*PRIO_W-1:0] prio_i,
    input  logic [N_IRQ*N_CPU-1:0]  tgt_i,
    input  logic [1:0]              dist_grp_en_i,
    input  logic [2*N_CPU-1:0]      cpu_grp_en_i,
    input  logic [N_CPU-1:0]        cpu_fiq_en_i,
    input  logic [N_CPU*PRIO_W-1:0] pmask_i,
    input  logic [N_CPU*PRIO_W-1:0] rprio_i,
    output logic [N_CPU-1:0]        irq_o,
    output logic [N_CPU-1:0]        fiq_o,
    output logic [N_CPU*ID_W-1:0]   cur_id_o
);
    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic [ID_W-1:0] best_id;
        logic [PRIO_W:0] best_prio;
        logic            best_grp;

        prio_pick #(
            .N_IRQ(N_IRQ), .N_CPU(N_CPU), .PRIO_W(PRIO_W), .CPU_IDX(c)
        ) u_pick (
            .pend_i(pend_i), .en_i(en_i), .grp_i(grp_i),
            .prio_i(prio_i), .tgt_i(tgt_i),
            .best_id_o(best_id), .best_prio_o(best_prio), .best_grp_o(best_grp)
        );

        prio_route #(.PRIO_W(PRIO_W)) u_route (
            .clk(clk), .rst_n(rst_n),
            .best_id_i(best_id), .best_prio_i(best_prio), .best_grp_i(best_grp),
            .dist_en_i(dist_grp_en_i),
            .cpu_en_i(cpu_grp_en_i[c*2 +: 2]),
            .fiq_en_i(cpu_fiq_en_i[c]),
            .pmask_i(pmask_i[c*PRIO_W +: PRIO_W]),
            .rprio_i(rprio_i[c*PRIO_W +: PRIO_W]),
            .irq_o(irq_o[c]), .fiq_o(fiq_o[c]),
            .cur_id_o(cur_id_o[c*ID_W +: ID_W])
        );
    end
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk
    import prio_res_pkg::*;
#(
    parameter int N_IRQ  = 64,
    parameter int N_CPU  = 2,
    parameter int PRIO_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IRQ-1:0]        pend_i,
    input  logic [N_IRQ-1:0]        en_i,
    input  logic [N_IRQ-1:0]        grp_i,
    input  logic [N_IRQ*PRIO_W-1:0] prio_i,
    input  logic [N_IRQ*N_CPU-1:0]  tgt_i,
    input  logic [1:0]              dist_grp_en_i,
    input  logic [2*N_CPU-1:0]      cpu_grp_en_i,
    input  logic [N_CPU-1:0]        cpu_fiq_en_i,
    input  logic [N_CPU*PRIO_W-1:0] pmask_i,
    input  logic [N_CPU*PRIO_W-1:0] rprio_i,
    input  logic [N_CPU-1:0]        irq_o,
    input  logic [N_CPU-1:0]        fiq_o,
    input  logic [N_CPU*ID_W-1:0]   cur_id_o
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_chk
        AST_LINES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(irq_o[c] && fiq_o[c])); // R9

        AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && ($past(dist_grp_en_i) == 2'b00 ||
                         $past(cpu_grp_en_i[c*2 +: 2]) == 2'b00))
            |-> (!irq_o[c] && !fiq_o[c])); // R6

        AST_FIQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && fiq_o[c]) |-> $past(cpu_fiq_en_i[c])); // R8

        AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (cur_id_o[c*ID_W +: ID_W] == SPURIOUS_ID) |-> (!irq_o[c] && !fiq_o[c])); // R4

        AST_RUN_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(rprio_i[c*PRIO_W +: PRIO_W]) == '0)
            |-> (!irq_o[c] && !fiq_o[c])); // R5
    end
endmodule

bind prio_resolver prio_resolver_chk #(
    .N_IRQ(N_IRQ), .N_CPU(N_CPU), .PRIO_W(PRIO_W)
) u_chk (.*);

// File: tb/prio_resolver_tb.sv
module prio_resolver_tb;
    localparam int NI = 64;
    localparam int NC = 2;
    localparam int PW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NI-1:0]     pend_i, en_i, grp_i;
    logic [NI*PW-1:0]  prio_i;
    logic [NI*NC-1:0]  tgt_i;
    logic [1:0]        dist_grp_en_i;
    logic [2*NC-1:0]   cpu_grp_en_i;
    logic [NC-1:0]     cpu_fiq_en_i;
    logic [NC*PW-1:0]  pmask_i, rprio_i;
    logic [NC-1:0]     irq_o, fiq_o;
    logic [NC*10-1:0]  cur_id_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    prio_resolver #(.N_IRQ(NI), .N_CPU(NC), .PRIO_W(PW)) u_dut (.*);

    always #4 clk = ~clk;

    task automatic chk(string tag, int c, bit ei, bit ef, int eid);
        int aid;
        aid = int'(cur_id_o[c*10 +: 10]);
        tests++;
        if (irq_o[c] !== ei || fiq_o[c] !== ef || aid != eid) begin
            fails++;
            $display("FAIL %s cpu%0d: irq=%0b fiq=%0b id=%0d expected irq=%0b fiq=%0b id=%0d",
                     tag, c, irq_o[c], fiq_o[c], aid, ei, ef, eid);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    task automatic clear_src();
        pend_i = '0; en_i = '0; grp_i = '0; prio_i = '1; tgt_i = '0;
    endtask

    task automatic put(int id, int p, bit g, bit [1:0] t);
        pend_i[id] = 1'b1; en_i[id] = 1'b1; grp_i[id] = g;
        prio_i[id*PW +: PW] = p[7:0];
        tgt_i[id*NC +: NC] = t;
    endtask

    task automatic cfg(int c, bit [1:0] ge, bit fe, int m, int r);
        cpu_grp_en_i[c*2 +: 2] = ge;
        cpu_fiq_en_i[c] = fe;
        pmask_i[c*PW +: PW] = m[7:0];
        rprio_i[c*PW +: PW] = r[7:0];
    endtask

    task automatic open_all();
        dist_grp_en_i = 2'b11;
        cfg(0, 2'b11, 1'b0, 8'hFF, 8'hFF);
        cfg(1, 2'b11, 1'b0, 8'hFF, 8'hFF);
    endtask

    task automatic t_reset();
        clear_src(); open_all();
        put(3, 8'h10, 1'b1, 2'b11);
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset cpu0", 0, 0, 0, 1023);
        chk("R1 reset cpu1", 1, 0, 0, 1023);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic t_candidate();
        clear_src(); open_all();
        put(5, 8'h30, 1'b1, 2'b11);
        en_i[5] = 1'b0;
        settle();
        chk("R2 disabled source", 0, 0, 0, 1023);
        en_i[5] = 1'b1; pend_i[5] = 1'b0;
        settle();
        chk("R2 not pending", 0, 0, 0, 1023);
        pend_i[5] = 1'b1; tgt_i[5*NC +: NC] = 2'b10;
        settle();
        chk("R2 R11 not targeted cpu0", 0, 0, 0, 1023);
        chk("R2 R11 targeted cpu1", 1, 1, 0, 5);
    endtask

    task automatic t_priority();
        clear_src(); open_all();
        put(10, 8'h40, 1'b1, 2'b01);
        put(30, 8'h20, 1'b1, 2'b01);
        put(20, 8'h20, 1'b1, 2'b01);
        settle();
        chk("R3 lowest value, tie to lower id", 0, 1, 0, 20);
        put(0, 8'h00, 1'b1, 2'b01);
        put(NI-1, 8'h00, 1'b1, 2'b01);
        settle();
        chk("R3 tie at id 0", 0, 1, 0, 0);
        pend_i[0] = 1'b0;
        settle();
        chk("R3 top id wins", 0, 1, 0, NI-1);
    endtask

    task automatic t_thresholds();
        clear_src(); open_all();
        put(20, 8'h20, 1'b1, 2'b01);
        cfg(0, 2'b11, 1'b0, 8'h20, 8'hFF);
        settle();
        chk("R4 prio equal to mask", 0, 0, 0, 1023);
        cfg(0, 2'b11, 1'b0, 8'h21, 8'hFF);
        settle();
        chk("R4 prio below mask", 0, 1, 0, 20);
        cfg(0, 2'b11, 1'b0, 8'hFF, 8'h20);
        settle();
        chk("R5 equal running prio keeps id", 0, 0, 0, 20);
        cfg(0, 2'b11, 1'b0, 8'hFF, 8'h21);
        settle();
        chk("R5 below running prio", 0, 1, 0, 20);
    endtask

    task automatic t_global();
        clear_src(); open_all();
        put(7, 8'h08, 1'b0, 2'b11);
        dist_grp_en_i = 2'b00;
        settle();
        chk("R6 distributor off", 0, 0, 0, 7);
        open_all();
        cfg(1, 2'b00, 1'b0, 8'hFF, 8'hFF);
        settle();
        chk("R6 R11 cpu1 interface off", 1, 0, 0, 7);
        chk("R11 cpu0 unaffected", 0, 1, 0, 7);
    endtask

    task automatic t_group();
        clear_src(); open_all();
        put(4, 8'h10, 1'b1, 2'b01);
        put(9, 8'h50, 1'b0, 2'b01);
        dist_grp_en_i = 2'b01;
        settle();
        chk("R7 winner group off at distributor", 0, 0, 0, 4);
        open_all();
        cfg(0, 2'b01, 1'b0, 8'hFF, 8'hFF);
        settle();
        chk("R7 winner group off at cpu", 0, 0, 0, 4);
        cfg(0, 2'b10, 1'b0, 8'hFF, 8'hFF);
        settle();
        chk("R7 winner group on", 0, 1, 0, 4);
    endtask

    task automatic t_route();
        clear_src(); open_all();
        put(12, 8'h10, 1'b0, 2'b01);
        cfg(0, 2'b11, 1'b1, 8'hFF, 8'hFF);
        settle();
        chk("R8 R9 group0 fast enabled", 0, 0, 1, 12);
        cfg(0, 2'b11, 1'b0, 8'hFF, 8'hFF);
        settle();
        chk("R8 group0 fast disabled", 0, 1, 0, 12);
        grp_i[12] = 1'b1;
        cfg(0, 2'b11, 1'b1, 8'hFF, 8'hFF);
        settle();
        chk("R8 group1 with fast enabled", 0, 1, 0, 12);
    endtask

    task automatic t_latency();
        clear_src(); open_all();
        put(2, 8'h40, 1'b0, 2'b01);
        cfg(0, 2'b11, 1'b1, 8'hFF, 8'hFF);
        settle();
        chk("R10 before change", 0, 0, 1, 2);
        put(1, 8'h30, 1'b1, 2'b01);
        #3;
        chk("R10 unchanged between edges", 0, 0, 1, 2);
        settle();
        chk("R10 updated at edge", 0, 1, 0, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_candidate();
        t_priority();
        t_thresholds();
        t_global();
        t_group();
        t_route();
        t_latency();
        finish_run();
    end

    initial begin
        #(8 * 100000);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end
endmodule